// File: doc/BRIEF.md
# Bidirectional Strobed Port Controller

This block runs one 8-bit port as a shared two-way bus between a host processor and a peer processor, with five handshake lines beside it. When the host writes a byte, the byte is held in an output latch, and an active-low "output full" line tells the peer that data is waiting. The peer takes the byte by pulling its acknowledge line low. The latch drives the shared bus only while acknowledge is low. In the other direction, the peer places a byte on the bus and pulls its strobe low. The byte is captured into an input latch and an "input full" flag rises. The flag clears when the host reads the port.

The host selects the bidirectional mode with a control word. It then sets or clears one interrupt enable for each direction using single-bit commands. Both enables feed one shared interrupt request line. A fixed-layout status byte reports all the handshake flags and both enables.

Top module: `bidir_port_ctrl`

## Requirements
- R1: After a synchronous reset, `obf_n` is 1, `ibf` is 0, both enables are 0, the mode is inactive, `bus_oe` is 0, `intr` is 0 and `status` is 8'h80.
- R2: A control write with bit 7 = 1 is a mode word. It sets the mode active when bits 7:6 = 2'b11 and inactive otherwise. In both cases it clears both enables, sets `obf_n` to 1 and clears `ibf` on the next edge.
- R3: While the mode is active, a `wr_port` pulse latches `wdata` and drives `obf_n` low on the next edge.
- R4: `bus_oe` is 1 exactly while the mode is active and `ack_n` is 0. During that time `bus_out` carries the output latch. A cycle with `ack_n` = 0 and no write sets `obf_n` to 1 on the next edge.
- R5: While the mode is active, a cycle with `stb_n` = 0 captures `bus_in` into the input latch and sets `ibf` on the next edge. `port_rdata` always shows the input latch.
- R6: A `rd_port` pulse with `stb_n` = 1 clears `ibf` on the next edge.
- R7: A control write with bit 7 = 0 is a single-bit command. Bits 3:1 select a line and bit 0 is the new value. Only while the mode is active, line 6 writes the output-direction enable and line 4 writes the input-direction enable. Any other line leaves both enables unchanged.
- R8: `intr` = active & ((out_en & `obf_n` & `ack_n`) | (in_en & `ibf` & `stb_n`)), evaluated combinationally.
- R9: `status` = {`obf_n`, out_en, `ibf`, in_en, `intr`, 3'b000}, with bit 7 as the most significant bit.
- R10: While the mode is inactive, `wr_port` and `stb_n` have no effect: `obf_n` stays 1 and `ibf` stays 0.
- R11: A write in the same cycle as `ack_n` = 0 leaves `obf_n` low. A strobe in the same cycle as `rd_port` leaves `ibf` high. A mode word beats a port write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_data | input | 8 | Control word |
| wr_port | input | 1 | Host write to the data port |
| wdata | input | 8 | Host write data |
| rd_port | input | 1 | Host read of the data port |
| port_rdata | output | 8 | Input latch contents |
| status | output | 8 | Packed status byte |
| ack_n | input | 1 | Peer acknowledge, active low |
| stb_n | input | 1 | Peer strobe, active low |
| bus_in | input | 8 | Shared bus value seen at the pins |
| bus_out | output | 8 | Value to drive onto the shared bus |
| bus_oe | output | 1 | Bus output enable |
| obf_n | output | 1 | Output full, active low |
| ibf | output | 1 | Input full |
| intr | output | 1 | Shared interrupt request |

## Verification
The assertions check the following on every cycle:
- the effect of mode words on the flags and enables;
- `obf_n` falling after a write and rising after an acknowledge;
- `ibf` rising after a strobe and falling after a read;
- the flags staying idle while the mode is inactive.

Some behaviour only the bench scenarios can show. These include the decoding of all sixteen single-bit commands, and data integrity in both directions over every byte value. They also include every combination of enables, flags and handshake levels feeding the shared interrupt, and the same-cycle priority cases.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    localparam int unsigned STATUS_W = 8;
    localparam logic [2:0]  SEL_OUT_EN = 3'd6;
    localparam logic [2:0]  SEL_IN_EN  = 3'd4;

    typedef struct packed {
        logic       is_mode;
        logic       bidir;
        logic [2:0] bit_sel;
        logic       bit_val;
    } ctl_word_t;

    typedef struct packed {
        logic obf_n;
        logic out_en;
        logic ibf;
        logic in_en;
        logic irq;
    } flag_set_t;

    function automatic ctl_word_t decode_ctl(input logic [7:0] w);
        ctl_word_t c;
        c.is_mode = w[7];
        c.bidir   = w[7] & w[6];
        c.bit_sel = w[3:1];
        c.bit_val = w[0];
        return c;
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(input flag_set_t f);
        return {f.obf_n, f.out_en, f.ibf, f.in_en, f.irq, 3'b000};
    endfunction

endpackage

// File: rtl/bpc_ctrl_regs.sv
module bpc_ctrl_regs
    import bpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_data,
    output logic       mode_on,
    output logic       mode_clr,
    output logic       out_en,
    output logic       in_en
);

    ctl_word_t cw;

    always_comb begin
        cw       = decode_ctl(ctrl_data);
        mode_clr = ctrl_wr & cw.is_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_on <= 1'b0;
            out_en  <= 1'b0;
            in_en   <= 1'b0;
        end else if (ctrl_wr) begin
            if (cw.is_mode) begin
                mode_on <= cw.bidir;
                out_en  <= 1'b0;
                in_en   <= 1'b0;
            end else if (mode_on) begin
                if (cw.bit_sel == SEL_OUT_EN) out_en <= cw.bit_val;
                if (cw.bit_sel == SEL_IN_EN)  in_en  <= cw.bit_val;
            end
        end
    end

    // R2
    mode_word_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_data[7]) |=> (mode_on == $past(ctrl_data[6]) && !out_en && !in_en));

    // R7
    bit_cmd_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ctrl_data[7] && ctrl_data[3:1] != SEL_OUT_EN && ctrl_data[3:1] != SEL_IN_EN)
        |=> ($stable(out_en) && $stable(in_en)));

endmodule

// File: rtl/bpc_out_path.sv
module bpc_out_path #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_on,
    input  logic              mode_clr,
    input  logic              wr_port,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_n,
    output logic              obf_n,
    output logic [DATA_W-1:0] out_latch
);

    always_ff @(posedge clk) begin
        if (rst) begin
            obf_n     <= 1'b1;
            out_latch <= '0;
        end else if (mode_clr) begin
            obf_n <= 1'b1;
        end else if (mode_on) begin
            if (wr_port) begin
                out_latch <= wdata;
                obf_n     <= 1'b0;
            end else if (!ack_n) begin
                obf_n <= 1'b1;
            end
        end
    end

    // R3
    write_full_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_port && mode_on && !mode_clr) |=> (!obf_n && out_latch == $past(wdata)));

    // R4
    ack_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !wr_port && mode_on) |=> obf_n);

    // R10
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_on) |=> obf_n);

endmodule

// File: rtl/bpc_in_path.sv
module bpc_in_path #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_on,
    input  logic              mode_clr,
    input  logic              stb_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              rd_port,
    output logic              ibf,
    output logic [DATA_W-1:0] in_latch
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ibf      <= 1'b0;
            in_latch <= '0;
        end else if (mode_clr) begin
            ibf <= 1'b0;
        end else if (mode_on && !stb_n) begin
            in_latch <= bus_in;
            ibf      <= 1'b1;
        end else if (rd_port) begin
            ibf <= 1'b0;
        end
    end

    // R5
    strobe_full_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb_n && mode_on && !mode_clr) |=> (ibf && in_latch == $past(bus_in)));

    // R6
    read_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_port && stb_n) |=> !ibf);

    // R10
    idle_in_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_on) |=> !ibf);

endmodule

// File: rtl/bidir_port_ctrl.sv
module bidir_port_ctrl
    import bpc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [7:0]        ctrl_data,
    input  logic              wr_port,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_port,
    output logic [DATA_W-1:0] port_rdata,
    output logic [7:0]        status,
    input  logic              ack_n,
    input  logic              stb_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              obf_n,
    output logic              ibf,
    output logic              intr
);

    logic              mode_on, mode_clr, out_en, in_en;
    logic [DATA_W-1:0] out_latch, in_latch;
    flag_set_t         flags;

    bpc_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .ctrl_data(ctrl_data),
        .mode_on  (mode_on),
        .mode_clr (mode_clr),
        .out_en   (out_en),
        .in_en    (in_en)
    );

    bpc_out_path #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .mode_on  (mode_on),
        .mode_clr (mode_clr),
        .wr_port  (wr_port),
        .wdata    (wdata),
        .ack_n    (ack_n),
        .obf_n    (obf_n),
        .out_latch(out_latch)
    );

    bpc_in_path #(.DATA_W(DATA_W)) u_in (
        .clk     (clk),
        .rst     (rst),
        .mode_on (mode_on),
        .mode_clr(mode_clr),
        .stb_n   (stb_n),
        .bus_in  (bus_in),
        .rd_port (rd_port),
        .ibf     (ibf),
        .in_latch(in_latch)
    );

    always_comb begin
        bus_oe     = mode_on & ~ack_n;
        bus_out    = out_latch;
        port_rdata = in_latch;
        intr       = mode_on & ((out_en & obf_n & ack_n) | (in_en & ibf & stb_n));
        flags      = '{obf_n: obf_n, out_en: out_en, ibf: ibf, in_en: in_en, irq: intr};
        status     = pack_status(flags);
    end

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        intr |-> (mode_on && (out_en || in_en)));

endmodule

// File: tb/sim_bidir_port_ctrl.sv
module sim_bidir_port_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       ctrl_wr;
    logic [7:0] ctrl_data;
    logic       wr_port;
    logic [7:0] wdata;
    logic       rd_port;
    logic [7:0] port_rdata;
    logic [7:0] status;
    logic       ack_n;
    logic       stb_n;
    logic [7:0] bus_in;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       obf_n;
    logic       ibf;
    logic       intr;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_port_ctrl u0 (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .wr_port(wr_port), .wdata(wdata), .rd_port(rd_port),
        .port_rdata(port_rdata), .status(status), .ack_n(ack_n),
        .stb_n(stb_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .obf_n(obf_n), .ibf(ibf), .intr(intr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctrl(input logic [7:0] w);
        ctrl_wr = 1'b1; ctrl_data = w;
        step();
        ctrl_wr = 1'b0;
    endtask

    task automatic port_write(input logic [7:0] v);
        wr_port = 1'b1; wdata = v;
        step();
        wr_port = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] v);
        stb_n = 1'b0; bus_in = v;
        step();
        stb_n = 1'b1;
    endtask

    task automatic port_read();
        rd_port = 1'b1;
        step();
        rd_port = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; ctrl_wr = 1'b0; ctrl_data = '0; wr_port = 1'b0; wdata = '0;
        rd_port = 1'b0; ack_n = 1'b1; stb_n = 1'b1; bus_in = '0;
        @(negedge clk);
        step(); step();
        rst = 1'b0;

        // R1 reset state
        check("R1 obf_n", obf_n, 1);
        check("R1 ibf", ibf, 0);
        check("R1 intr", intr, 0);
        check("R1 bus_oe", bus_oe, 0);
        check("R1 status", status, 8'h80);

        // R10 inactive mode ignores write and strobe
        port_write(8'h3C);
        check("R10 obf_n", obf_n, 1);
        strobe(8'h77);
        check("R10 ibf", ibf, 0);
        ack_n = 1'b0; #1;
        check("R10 bus_oe", bus_oe, 0);
        ack_n = 1'b1;

        // R2 enter bidirectional mode
        ctrl(8'hC0);
        check("R2 status", status, 8'h80);
        ack_n = 1'b0; #1;
        check("R2 bus_oe active", bus_oe, 1);
        ack_n = 1'b1;

        // R7 sweep of all single-bit commands
        for (int sel = 0; sel < 8; sel++) begin
            for (int val = 0; val < 2; val++) begin
                ctrl(8'hC0);
                ctrl({4'b0000, sel[2:0], val[0]});
                check("R7 out_en", status[6], (sel == 6) && (val == 1));
                check("R7 in_en", status[4], (sel == 4) && (val == 1));
            end
        end
        ctrl(8'h0D); ctrl(8'h09);
        ctrl(8'h0C);
        check("R7 out_en clear", status[6], 0);
        check("R7 in_en kept", status[4], 1);
        ctrl(8'h02);
        check("R7 other line no effect", status[6:4], 3'b001);
        ctrl(8'hC0);

        // R3 R4 R5 R6 data sweep over every byte value
        for (int v = 0; v < 256; v++) begin
            port_write(v[7:0]);
            check("R3 obf_n low", obf_n, 0);
            check("R9 status bit7", status[7], 0);
            ack_n = 1'b0; #1;
            check("R4 bus_oe", bus_oe, 1);
            check("R4 bus_out", bus_out, v[7:0]);
            step();
            ack_n = 1'b1;
            check("R4 obf_n high", obf_n, 1);
            strobe(v[7:0] ^ 8'hA5);
            check("R5 ibf", ibf, 1);
            check("R5 port_rdata", port_rdata, v[7:0] ^ 8'hA5);
            check("R9 status bit5", status[5], 1);
            port_read();
            check("R6 ibf cleared", ibf, 0);
        end

        // R8 R9 interrupt and status over all combinations
        for (int k = 0; k < 64; k++) begin
            logic oe, ie, full, inb, a, s, exp_irq;
            oe = k[0]; ie = k[1]; full = k[2]; inb = k[3]; a = k[4]; s = k[5];
            ctrl(8'hC0);
            ctrl({7'b0000110, oe});
            ctrl({7'b0000100, ie});
            if (full) port_write(8'h11);
            if (inb) strobe(8'h22);
            ack_n = a; stb_n = s; #1;
            exp_irq = (oe & ~full & a) | (ie & inb & s);
            check("R8 intr", intr, exp_irq);
            check("R9 status", status, {~full, oe, inb, ie, exp_irq, 3'b000});
            ack_n = 1'b1; stb_n = 1'b1;
            step();
        end

        // R11 same-cycle priorities
        ctrl(8'hC0);
        wr_port = 1'b1; wdata = 8'h5E; ack_n = 1'b0;
        step();
        wr_port = 1'b0; ack_n = 1'b1;
        check("R11 write beats ack", obf_n, 0);
        stb_n = 1'b0; bus_in = 8'h6B; rd_port = 1'b1;
        step();
        stb_n = 1'b1; rd_port = 1'b0;
        check("R11 strobe beats read", ibf, 1);
        ctrl_wr = 1'b1; ctrl_data = 8'hC0; wr_port = 1'b1; wdata = 8'h99;
        step();
        ctrl_wr = 1'b0; wr_port = 1'b0;
        check("R11 mode word beats write", obf_n, 1);
        check("R11 mode word clears ibf", ibf, 0);

        // R2 non-bidirectional mode word leaves the mode
        port_write(8'h44);
        strobe(8'h55);
        ctrl(8'h80);
        check("R2 obf_n after mode exit", obf_n, 1);
        check("R2 ibf after mode exit", ibf, 0);
        ack_n = 1'b0; #1;
        check("R2 bus_oe inactive", bus_oe, 0);
        ack_n = 1'b1;

        summary();
        $finish;
    end

endmodule